// File: doc/BRIEF.md
# Strided Multi-Register Predicated Store Sequencer

This block turns one decoded vector store into a stream of 8-byte memory writes. A request names a 64-bit base, a 64-bit element index, a selector for two or four source registers, the bits that build the first register number, and a governing mask with one bit per 64-bit element slot. The source registers are not adjacent in the register file: a two-register group is spaced 8 apart, and a four-register group is spaced 4 apart.

The sequencer walks the element slots in a fixed order: registers first to last, and within each register element 0 upward. For each register it drives a register-file read address and takes the element lane from the returned vector. Every slot moves the write address on by 8 bytes. A write is issued only for slots whose mask bit is set, through a valid/ready handshake. When the base comes from the stack pointer, the base must be 16-byte aligned. A misaligned stack-pointer base ends the request at once with a fault and no writes.

Top module: `strided_store_seq`

## Requirements
- R1: After reset, busy, done, fault and wr_valid are 0 and req_ready is 1.
- R2: A request is taken on a clock edge where req_valid and req_ready are both 1. From the next cycle, busy is 1 until the last slot completes. In the cycle after that, busy is 0 and done is 1 for exactly one cycle.
- R3: With req_quad = 0 (pair mode) there are 2*ELEMS slots. The first register number is {req_hi, 1'b0, req_zt[2:0]} and the second is that number plus 8.
- R4: With req_quad = 1 (quad mode) there are 4*ELEMS slots. The first register number is {req_hi, 2'b00, req_zt[1:0]} and each following register adds 4.
- R5: Slot s = r*ELEMS + e, where r is the register position and e is the element, is handled in ascending s. A write is issued for slot s only when req_mask[s] is 1. The write carries bits [e*64 +: 64] of rf_data read at that register's number.
- R6: The write address of slot s is req_base + req_index*8 + 8*s, modulo 2^64. Slots with a cleared mask bit still advance the address, and each such slot takes one cycle.
- R7: While wr_valid is 1 and wr_ready is 0, wr_valid stays 1 and wr_addr and wr_data hold. Each stall cycle lengthens busy by one cycle.
- R8: In pair mode, mask bits at positions 2*ELEMS and above have no effect.
- R9: If req_base_is_sp is 1 and req_base[3:0] is not zero, no write is issued and busy stays 0. In the cycle after acceptance, done and fault are both 1 for one cycle. This holds whatever the mask is.
- R10: A request with every relevant mask bit clear, and no fault, issues no write. It still holds busy for exactly one cycle per slot before done.
- R11: While busy is 1, req_ready is 0, and req_valid together with the request fields is ignored.
- R12: A 16-byte-aligned stack-pointer base, or a misaligned base that is not the stack pointer, is handled as a normal request with no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (idle) |
| req_base | input | 64 | Base address |
| req_index | input | 64 | Element index, scaled by 8 |
| req_hi | input | 1 | High bit of the first register number |
| req_zt | input | 3 | Low register field |
| req_quad | input | 1 | 0: two registers, 1: four registers |
| req_base_is_sp | input | 1 | Base is the stack pointer (alignment checked) |
| req_mask | input | 4*VLEN/64 | Governing mask, bit s for slot s |
| rf_addr | output | 5 | Register-file read address |
| rf_data | input | VLEN | Register contents at rf_addr, same cycle |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | 64 | Byte address of the 8-byte write |
| wr_data | output | 64 | Write data |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Alignment fault, pulses with done |

## Verification
A wrong slot counter or register step shows up on the first write after the bad transition, as a wrong wr_data lane or register. A wrong address increment shows on the next active slot's wr_addr. A mishandled stall shows in the very cycle after wr_ready is low, as a dropped wr_valid or a moved address. An off-by-one in the last-slot decision shows as an extra or missing write, or as a busy length that does not equal slots plus stalls. The done or fault pulse would then be seen up to one cycle late or early. A fault path that leaks state shows as busy or wr_valid rising after a misaligned stack-pointer request.

// File: rtl/sss_pkg.sv
package sss_pkg;
    localparam int REG_W         = 5;
    localparam int ELEM_BITS     = 64;
    localparam int ELEM_SHIFT    = 3;   // log2 of bytes per element
    localparam int SP_ALIGN_BITS = 4;   // stack base must be 16-byte aligned

    typedef logic [REG_W-1:0] vreg_t;

    typedef enum logic {
        GRP_PAIR = 1'b0,
        GRP_QUAD = 1'b1
    } grp_mode_e;
endpackage

// File: rtl/sss_reg_plan.sv
module sss_reg_plan
    import sss_pkg::*;
(
    input  logic      hi,
    input  logic [2:0] zt,
    input  grp_mode_e mode,
    output vreg_t     first_reg,
    output vreg_t     reg_stride
);
    always_comb begin
        if (mode == GRP_QUAD) begin
            first_reg  = {hi, 2'b00, zt[1:0]};
            reg_stride = vreg_t'(4);
        end else begin
            first_reg  = {hi, 1'b0, zt};
            reg_stride = vreg_t'(8);
        end
    end
endmodule

// File: rtl/sss_start_addr.sv
module sss_start_addr
    import sss_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] index,
    input  logic              base_is_sp,
    output logic [ADDR_W-1:0] start,
    output logic              misaligned
);
    always_comb begin
        start      = base + (index << ELEM_SHIFT);
        misaligned = base_is_sp && (base[SP_ALIGN_BITS-1:0] != '0);
    end
endmodule

// File: rtl/sss_slot_pick.sv
module sss_slot_pick
    import sss_pkg::*;
#(
    parameter int VLEN   = 128,
    parameter int MASK_W = 8,
    parameter int SLOT_W = 3
) (
    input  logic [MASK_W-1:0]    mask,
    input  logic [SLOT_W-1:0]    slot,
    input  logic [VLEN-1:0]      rf_data,
    output logic                 active,
    output logic [ELEM_BITS-1:0] elem_data,
    output logic                 reg_end
);
    localparam int ELEMS  = VLEN / ELEM_BITS;
    localparam int EIDX_W = $clog2(ELEMS);

    logic [ELEM_BITS-1:0] lanes [ELEMS];
    logic [EIDX_W-1:0]    eidx;

    for (genvar g = 0; g < ELEMS; g++) begin : g_lane
        assign lanes[g] = rf_data[g*ELEM_BITS +: ELEM_BITS];
    end

    always_comb begin
        eidx      = slot[EIDX_W-1:0];
        elem_data = lanes[eidx];
        active    = mask[slot];
        reg_end   = (eidx == EIDX_W'(ELEMS - 1));
    end
endmodule

// File: rtl/strided_store_seq.sv
module strided_store_seq
    import sss_pkg::*;
#(
    parameter int VLEN   = 128,
    parameter int ADDR_W = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [ADDR_W-1:0]          req_base,
    input  logic [ADDR_W-1:0]          req_index,
    input  logic                       req_hi,
    input  logic [2:0]                 req_zt,
    input  logic                       req_quad,
    input  logic                       req_base_is_sp,
    input  logic [4*VLEN/64-1:0]       req_mask,
    output logic [4:0]                 rf_addr,
    input  logic [VLEN-1:0]            rf_data,
    output logic                       wr_valid,
    input  logic                       wr_ready,
    output logic [ADDR_W-1:0]          wr_addr,
    output logic [63:0]                wr_data,
    output logic                       busy,
    output logic                       done,
    output logic                       fault
);
    localparam int ELEMS     = VLEN / ELEM_BITS;
    localparam int MASK_W    = 4 * ELEMS;
    localparam int SLOT_W    = $clog2(MASK_W);
    localparam int BYTES     = ELEM_BITS / 8;
    localparam logic [SLOT_W-1:0] LAST_PAIR = SLOT_W'(2 * ELEMS - 1);
    localparam logic [SLOT_W-1:0] LAST_QUAD = SLOT_W'(4 * ELEMS - 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              fault;
        grp_mode_e         mode;
        vreg_t             reg_cur;
        vreg_t             stride;
        logic [SLOT_W-1:0] slot;
        logic [ADDR_W-1:0] addr;
        logic [MASK_W-1:0] mask;
    } seq_state_t;

    seq_state_t st_d, st_q;

    grp_mode_e            req_mode;
    vreg_t                first_reg, reg_stride;
    logic [ADDR_W-1:0]    start_addr;
    logic                 misaligned;
    logic                 slot_active, slot_reg_end;
    logic [ELEM_BITS-1:0] slot_data;
    logic                 slot_done, slot_last;

    assign req_mode = req_quad ? GRP_QUAD : GRP_PAIR;

    sss_reg_plan u_plan (
        .hi         (req_hi),
        .zt         (req_zt),
        .mode       (req_mode),
        .first_reg  (first_reg),
        .reg_stride (reg_stride)
    );

    sss_start_addr #(.ADDR_W(ADDR_W)) u_start (
        .base       (req_base),
        .index      (req_index),
        .base_is_sp (req_base_is_sp),
        .start      (start_addr),
        .misaligned (misaligned)
    );

    sss_slot_pick #(.VLEN(VLEN), .MASK_W(MASK_W), .SLOT_W(SLOT_W)) u_pick (
        .mask      (st_q.mask),
        .slot      (st_q.slot),
        .rf_data   (rf_data),
        .active    (slot_active),
        .elem_data (slot_data),
        .reg_end   (slot_reg_end)
    );

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.fault = 1'b0;
        slot_done  = st_q.busy && (!slot_active || wr_ready);
        slot_last  = (st_q.slot == ((st_q.mode == GRP_QUAD) ? LAST_QUAD : LAST_PAIR));

        if (!st_q.busy) begin
            if (req_valid) begin
                if (misaligned) begin
                    st_d.done  = 1'b1;
                    st_d.fault = 1'b1;
                end else begin
                    st_d.busy    = 1'b1;
                    st_d.mode    = req_mode;
                    st_d.reg_cur = first_reg;
                    st_d.stride  = reg_stride;
                    st_d.slot    = '0;
                    st_d.addr    = start_addr;
                    st_d.mask    = req_mask;
                end
            end
        end else if (slot_done) begin
            st_d.addr = st_q.addr + ADDR_W'(BYTES);
            if (slot_last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.slot = st_q.slot + 1'b1;
                if (slot_reg_end) begin
                    st_d.reg_cur = st_q.reg_cur + st_q.stride;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = !st_q.busy;
    assign rf_addr   = st_q.reg_cur;
    assign wr_valid  = st_q.busy && slot_active;
    assign wr_addr   = st_q.addr;
    assign wr_data   = slot_data;
    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign fault     = st_q.fault;
endmodule

// File: rtl/sss_checker.sv
module sss_checker #(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [4:0]        rf_addr,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              busy,
    input logic              done,
    input logic              fault
);
    AST_WR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> busy); // R5

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr))); // R7

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && req_ready)); // R2

    AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done); // R2

    AST_FAULT_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (done && !wr_valid)); // R9

    AST_REG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && rf_addr != $past(rf_addr))
        |-> ((5'(rf_addr - $past(rf_addr)) == 5'd4) || (5'(rf_addr - $past(rf_addr)) == 5'd8))); // R3 R4

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && wr_valid && $past(wr_valid) && $past(wr_ready))
        |-> (wr_addr == $past(wr_addr) + ADDR_W'(8))); // R6
endmodule

bind strided_store_seq sss_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rf_addr   (rf_addr),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_addr   (wr_addr),
    .busy      (busy),
    .done      (done),
    .fault     (fault)
);

// File: tb/strided_store_seq_tb.sv
module strided_store_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int VLEN   = 128;
    localparam int ELEMS  = VLEN / 64;
    localparam int MASK_W = 4 * ELEMS;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [63:0]       req_base = '0;
    logic [63:0]       req_index = '0;
    logic              req_hi = 1'b0;
    logic [2:0]        req_zt = '0;
    logic              req_quad = 1'b0;
    logic              req_base_is_sp = 1'b0;
    logic [MASK_W-1:0] req_mask = '0;
    logic [4:0]        rf_addr;
    logic [VLEN-1:0]   rf_data;
    logic              wr_valid;
    logic              wr_ready = 1'b1;
    logic [63:0]       wr_addr;
    logic [63:0]       wr_data;
    logic              busy, done, fault;

    logic [VLEN-1:0] rf [32];
    assign rf_data = rf[rf_addr];

    int nchk = 0;
    int nerr = 0;

    logic [63:0] exp_addr [MASK_W];
    logic [63:0] exp_data [MASK_W];

    always #(CLK_PERIOD/2) clk = ~clk;

    strided_store_seq #(.VLEN(VLEN), .ADDR_W(64)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_base(req_base), .req_index(req_index),
        .req_hi(req_hi), .req_zt(req_zt), .req_quad(req_quad),
        .req_base_is_sp(req_base_is_sp), .req_mask(req_mask),
        .rf_addr(rf_addr), .rf_data(rf_data),
        .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .fault(fault)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [4:0] first_reg(input logic hi, input logic [2:0] zt, input logic quad);
        return quad ? {hi, 2'b00, zt[1:0]} : {hi, 1'b0, zt};
    endfunction

    // ready_mode 0: always ready, 1: random ready
    task automatic run_case(input logic [63:0] base, input logic [63:0] idx, input logic hi,
                            input logic [2:0] zt, input logic quad, input logic sp,
                            input logic [MASK_W-1:0] mask, input bit ready_mode, input string tag);
        int nreg, nslot, exp_n, got, busy_cnt, stall_cnt, cyc;
        logic [4:0] fr;
        logic [4:0] stride;
        logic bad, prev_stall;
        logic [63:0] prev_addr;
        nreg   = quad ? 4 : 2;
        nslot  = nreg * ELEMS;
        fr     = first_reg(hi, zt, quad);
        stride = quad ? 5'd4 : 5'd8;
        bad    = sp && (base[3:0] != 4'h0);
        exp_n  = 0;
        if (!bad) begin
            for (int s = 0; s < nslot; s++) begin
                if (mask[s]) begin
                    logic [4:0] rn;
                    rn = fr + 5'(stride * (s / ELEMS));
                    exp_addr[exp_n] = base + (idx << 3) + 64'(8 * s);
                    exp_data[exp_n] = rf[rn][(s % ELEMS)*64 +: 64];
                    exp_n++;
                end
            end
        end
        @(negedge clk);
        #1;
        check(req_ready === 1'b1, {"R11 idle ready ", tag}, 64'(req_ready), 64'd1);
        req_base = base; req_index = idx; req_hi = hi; req_zt = zt;
        req_quad = quad; req_base_is_sp = sp; req_mask = mask; req_valid = 1'b1;
        got = 0; busy_cnt = 0; stall_cnt = 0; cyc = 0;
        prev_stall = 1'b0; prev_addr = '0;
        forever begin
            @(negedge clk);
            wr_ready = ready_mode ? (($urandom % 4) != 0) : 1'b1;
            if (cyc < 2 && !bad) begin
                // R11: a competing request while busy must be ignored
                req_valid = 1'b1;
                req_base = {$urandom, $urandom}; req_index = {$urandom, $urandom};
                req_hi = 1'($urandom); req_zt = 3'($urandom); req_quad = 1'($urandom);
                req_mask = MASK_W'($urandom); req_base_is_sp = 1'b0;
            end else begin
                req_valid = 1'b0;
            end
            #1;
            if (busy) begin
                busy_cnt++;
                check(req_ready === 1'b0, {"R11 ready while busy ", tag}, 64'(req_ready), 64'd0);
            end
            if (prev_stall) begin
                check(wr_valid === 1'b1 && wr_addr === prev_addr, {"R7 hold under stall ", tag}, wr_addr, prev_addr);
            end
            if (wr_valid === 1'b1) begin
                if (got < exp_n) begin
                    check(wr_addr === exp_addr[got], {"R6 write address ", tag}, wr_addr, exp_addr[got]);
                    check(wr_data === exp_data[got], {"R5 write data ", tag}, wr_data, exp_data[got]);
                end else begin
                    check(1'b0, {"R5 unexpected write ", tag}, wr_addr, 64'(exp_n));
                end
                if (wr_ready) got++;
                else stall_cnt++;
            end
            prev_stall = wr_valid && !wr_ready;
            prev_addr  = wr_addr;
            if (done === 1'b1) break;
            cyc++;
            if (cyc > 400) begin
                check(1'b0, {"R2 watchdog no done ", tag}, 64'(cyc), 64'd400);
                break;
            end
        end
        req_valid = 1'b0;
        wr_ready  = 1'b1;
        check(got == exp_n, {"R5 R10 write count ", tag}, 64'(got), 64'(exp_n));
        check(fault === bad, {"R9 R12 fault flag ", tag}, 64'(fault), 64'(bad));
        if (bad) begin
            check(busy_cnt == 0 && cyc == 0, {"R9 no busy on fault ", tag}, 64'(busy_cnt), 64'd0);
        end else begin
            check(busy_cnt == nslot + stall_cnt, {"R2 R6 R7 busy length ", tag}, 64'(busy_cnt), 64'(nslot + stall_cnt));
        end
        @(negedge clk);
        #1;
        check(done === 1'b0 && fault === 1'b0 && busy === 1'b0, {"R2 single done pulse ", tag}, 64'(done), 64'd0);
        check(wr_valid === 1'b0, {"R2 idle no write ", tag}, 64'(wr_valid), 64'd0);
    endtask

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        for (int i = 0; i < 32; i++) begin
            for (int e = 0; e < ELEMS; e++) begin
                rf[i][e*64 +: 64] = {8'(i), 8'(e), 16'($urandom), 32'($urandom)};
            end
        end
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check(busy === 1'b0 && done === 1'b0 && fault === 1'b0, "R1 reset status", {61'd0, busy, done, fault}, 64'd0);
        check(wr_valid === 1'b0, "R1 reset wr_valid", 64'(wr_valid), 64'd0);
        check(req_ready === 1'b1, "R1 reset req_ready", 64'(req_ready), 64'd1);
        rst_n = 1'b1;

        // R3 pair mode, full mask, steady ready
        run_case(64'h1000, 64'd4, 1'b1, 3'd5, 1'b0, 1'b0, 8'hFF, 1'b0, "R3 pair full");
        // R4 quad mode, full mask
        run_case(64'h2000, 64'd1, 1'b0, 3'd7, 1'b1, 1'b0, 8'hFF, 1'b0, "R4 quad full");
        // R10 empty masks
        run_case(64'h3000, 64'd0, 1'b0, 3'd2, 1'b0, 1'b0, 8'h00, 1'b0, "R10 pair empty");
        run_case(64'h3000, 64'd0, 1'b1, 3'd3, 1'b1, 1'b0, 8'h00, 1'b1, "R10 quad empty");
        // R8 upper mask bits in pair mode
        run_case(64'h4000, 64'd2, 1'b0, 3'd1, 1'b0, 1'b0, 8'hF0, 1'b0, "R8 pair upper only");
        run_case(64'h4000, 64'd2, 1'b1, 3'd6, 1'b0, 1'b0, 8'hA5, 1'b1, "R8 pair mixed");
        // R6 sparse mask with address wrap
        run_case(64'hFFFF_FFFF_FFFF_FFF0, 64'd1, 1'b1, 3'd0, 1'b1, 1'b0, 8'h81, 1'b0, "R6 wrap sparse");
        // R9 misaligned stack base, any mask
        run_case(64'h5008, 64'd3, 1'b0, 3'd0, 1'b1, 1'b1, 8'hFF, 1'b0, "R9 sp misaligned");
        run_case(64'h5001, 64'd0, 1'b0, 3'd0, 1'b0, 1'b1, 8'h00, 1'b0, "R9 sp misaligned empty");
        // R12 aligned stack base and misaligned ordinary base
        run_case(64'h6010, 64'd5, 1'b1, 3'd4, 1'b0, 1'b1, 8'h0F, 1'b1, "R12 sp aligned");
        run_case(64'h6003, 64'd5, 1'b0, 3'd4, 1'b1, 1'b0, 8'h3C, 1'b1, "R12 plain misaligned");

        // constrained random mix
        for (int n = 0; n < 250; n++) begin
            logic [63:0] b;
            b = {$urandom, $urandom};
            if (($urandom % 2) != 0) b[3:0] = 4'h0;
            run_case(b, {$urandom, $urandom}, 1'($urandom), 3'($urandom), 1'($urandom),
                     (($urandom % 4) == 0), MASK_W'($urandom), 1'b1, "R5 random");
        end

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL R2 global watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule